// File: doc/BRIEF.md
# Folded Linear-Phase FIR Filter with Approximate Adders

This block filters a stream of 12-bit two's-complement samples, taking one sample on every clock. It has 41 fixed taps with mirror symmetry. The two samples that meet the same coefficient are added before any multiplication, so 21 multipliers serve 41 taps. The products are then summed and scaled back to a 12-bit result.

The pre-add adders and the accumulation adders are each built from one adder whose low-order bits can be computed approximately. An elaboration parameter sets how many low bits are approximated. Setting it to zero gives exact addition, and setting it to the full adder width approximates every bit. The pre-add stage and the accumulation stage each have their own setting, so accuracy can be traded against carry-chain length and area.

The filter has four register stages: the delay line, the pre-add registers, the product registers and the output register. A valid flag marks the outputs once the delay line has been filled since reset.

Top module: `symFirApprox`

## Requirements
- R1: The output after clock edge n is computed from the delay-line contents after edge n-3. Delay-line entry j holds the sample captured j edges earlier (entry 0 is the newest).
- R2: The coefficient for mirrored pair k (k = 0..19, pairing entries k and 40-k) is 3k-10. The centre entry 20 uses coefficient 64.
- R3: With both approximation settings at zero, each pair sum is an exact 13-bit sum. Each product is kept to 24 bits. The 21 products are summed exactly in the order pair 0, pair 1, …, pair 19, centre. The output is floor((sum + 128) / 256).
- R4: Results above 2047 are clamped to 2047, and results below -2048 are clamped to -2048.
- R5: A pre-add setting of K (0 < K < 13) approximates the low K bits of the 13-bit sign-extended pair sum. Those bits are the bitwise OR of the operands' low K bits. The upper bits are the exact sum of the operands' upper bits plus a predicted carry, which is the AND of the two operands' bit K-1.
- R6: The accumulation setting applies the R5 rule to each 24-bit addition of the running sum with the next product, following the R3 order.
- R7: A setting equal to the adder width (13 for pre-add, 24 for accumulation) makes the whole sum the bitwise OR of the operands.
- R8: While reset is high at a clock edge, the delay line and every pipeline register are cleared. After that edge the output reads 0 and the valid flag is low.
- R9: After reset is released, the valid flag rises after the 44th clock edge and stays high until the next reset.
- R10: Once 44 consecutive captured inputs have been zero, the output is 0 in every setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| xIn | input | 12 | Raw signed sample, captured every cycle |
| yOut | output | 12 | Filtered, rounded and saturated signed sample |
| yValid | output | 1 | High once the delay line has been filled since reset |

## Verification
A wrong entry in the delay line or a wrong pre-add or product register cannot stay hidden. It reaches the output exactly three edges after it is written, and it then affects up to 41 consecutive outputs until it shifts out. The bench therefore compares every output in every cycle against an arithmetic model, using an exact instance, an intermediate-approximation instance and a fully approximate instance. A single wrong bit in the approximate low field or in the predicted carry shows up within three cycles wherever the stimulus exercises that bit. Fill-counter faults show up as the valid flag changing one edge early or late, or falling while it should stay high.

// File: rtl/firPkg.sv
package firPkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic clear;     // synchronous clear of all storage
    logic lineFull;  // delay line holds a full window of samples
  } firStrobes_t;

  // Coefficient of mirrored pair k; index taps/2 is the centre tap
  function automatic int coefOf(input int k, input int taps);
    if (k == taps / 2) return 64;
    return 3 * k - 10;
  endfunction

endpackage

// File: rtl/approxAdder.sv
module approxAdder #(
  parameter int W = 12,
  parameter int K = 0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  generate
    if (K <= 0) begin : g_exact
      assign s = a + b;
    end else if (K >= W) begin : g_allOr
      assign s = a | b;
    end else begin : g_split
      logic [K-1:0]   loPart;
      logic [W-K-1:0] hiPart;
      logic [W-K-1:0] carryIn;
      always_comb begin
        carryIn    = '0;
        carryIn[0] = a[K-1] & b[K-1];
        loPart     = a[K-1:0] | b[K-1:0];
        hiPart     = a[W-1:K] + b[W-1:K] + carryIn;
      end
      assign s = {hiPart, loPart};
    end
  endgenerate
endmodule

// File: rtl/firCtrl.sv
module firCtrl
  import firPkg::*;
#(
  parameter int TAPS = 41
) (
  input  logic        clk,
  input  logic        rst,
  output firStrobes_t stb
);
  localparam int CNT_W = $clog2(TAPS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(TAPS);

  logic [CNT_W-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst) fillCnt <= '0;
    else if (fillCnt != FULL_CNT) fillCnt <= fillCnt + 1'b1;
  end

  always_comb begin
    stb.clear    = rst;
    stb.lineFull = (fillCnt == FULL_CNT);
  end
endmodule

// File: rtl/firDatapath.sv
module firDatapath
  import firPkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int TAPS       = 41,
  parameter int COEF_W     = 12,
  parameter int ACC_W      = 24,
  parameter int SHIFT      = 8,
  parameter int PRE_APPROX = 0,
  parameter int ACC_APPROX = 0
) (
  input  logic                     clk,
  input  firStrobes_t              stb,
  input  logic signed [DATA_W-1:0] xIn,
  output logic signed [DATA_W-1:0] yOut,
  output logic                     yValid
);
  localparam int NPAIR  = TAPS / 2;
  localparam int NTERM  = NPAIR + 1;
  localparam int PW     = DATA_W + 1;
  localparam int PRODW  = PW + COEF_W;
  localparam logic signed [ACC_W:0] HALF_LSB = (ACC_W+1)'(1) <<< (SHIFT - 1);
  localparam logic signed [ACC_W:0] MAX_OUT  = (ACC_W+1)'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W:0] MIN_OUT  = -((ACC_W+1)'(1) <<< (DATA_W - 1));

  // Stage 1: delay line
  logic signed [DATA_W-1:0] line [TAPS];

  always_ff @(posedge clk) begin
    if (stb.clear) begin
      for (int i = 0; i < TAPS; i++) line[i] <= '0;
    end else begin
      line[0] <= xIn;
      for (int i = 1; i < TAPS; i++) line[i] <= line[i-1];
    end
  end

  // Stage 2: mirrored pre-add
  logic [PW-1:0]        preSum [NTERM];
  logic signed [PW-1:0] preReg [NTERM];

  generate
    for (genvar k = 0; k < NPAIR; k++) begin : g_pre
      logic [PW-1:0] opA, opB;
      assign opA = PW'(line[k]);
      assign opB = PW'(line[TAPS-1-k]);
      approxAdder #(.W(PW), .K(PRE_APPROX)) preAdd (
        .a(opA), .b(opB), .s(preSum[k])
      );
    end
  endgenerate
  assign preSum[NPAIR] = PW'(line[NPAIR]);

  // Stage 3: coefficient products
  logic signed [ACC_W-1:0] prodReg [NTERM];
  logic signed [ACC_W-1:0] prodNext [NTERM];

  generate
    for (genvar k = 0; k < NTERM; k++) begin : g_mul
      localparam logic signed [COEF_W-1:0] COEF = COEF_W'(coefOf(k, TAPS));
      logic signed [PRODW-1:0] fullProd;
      assign fullProd    = preReg[k] * COEF;
      assign prodNext[k] = ACC_W'(fullProd);
    end
  endgenerate

  // Stage 4 input: accumulation chain in fixed order
  logic [ACC_W-1:0] chain [NTERM];
  assign chain[0] = prodReg[0];

  generate
    for (genvar k = 1; k < NTERM; k++) begin : g_acc
      logic [ACC_W-1:0] nextTerm;
      assign nextTerm = prodReg[k];
      approxAdder #(.W(ACC_W), .K(ACC_APPROX)) accAdd (
        .a(chain[k-1]), .b(nextTerm), .s(chain[k])
      );
    end
  endgenerate

  // Rounding and saturation
  logic signed [ACC_W-1:0] accSum;
  logic signed [ACC_W:0]   biased;
  logic signed [ACC_W:0]   scaled;
  logic signed [DATA_W-1:0] clipped;

  always_comb begin
    accSum = chain[NTERM-1];
    biased = (ACC_W+1)'(accSum) + HALF_LSB;
    scaled = biased >>> SHIFT;
    if (scaled > MAX_OUT)      clipped = MAX_OUT[DATA_W-1:0];
    else if (scaled < MIN_OUT) clipped = MIN_OUT[DATA_W-1:0];
    else                       clipped = scaled[DATA_W-1:0];
  end

  // Pipeline registers and valid tracking
  logic vPre, vProd;

  always_ff @(posedge clk) begin
    if (stb.clear) begin
      for (int i = 0; i < NTERM; i++) begin
        preReg[i]  <= '0;
        prodReg[i] <= '0;
      end
      yOut   <= '0;
      vPre   <= 1'b0;
      vProd  <= 1'b0;
      yValid <= 1'b0;
    end else begin
      for (int i = 0; i < NTERM; i++) begin
        preReg[i]  <= preSum[i];
        prodReg[i] <= prodNext[i];
      end
      yOut   <= clipped;
      vPre   <= stb.lineFull;
      vProd  <= vPre;
      yValid <= vProd;
    end
  end
endmodule

// File: rtl/symFirApprox.sv
module symFirApprox
  import firPkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int TAPS       = 41,
  parameter int COEF_W     = 12,
  parameter int ACC_W      = 24,
  parameter int SHIFT      = 8,
  parameter int PRE_APPROX = 0,
  parameter int ACC_APPROX = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] xIn,
  output logic signed [DATA_W-1:0] yOut,
  output logic                     yValid
);
  firStrobes_t stb;

  firCtrl #(.TAPS(TAPS)) ctrl (
    .clk(clk), .rst(rst), .stb(stb)
  );

  firDatapath #(
    .DATA_W(DATA_W), .TAPS(TAPS), .COEF_W(COEF_W), .ACC_W(ACC_W),
    .SHIFT(SHIFT), .PRE_APPROX(PRE_APPROX), .ACC_APPROX(ACC_APPROX)
  ) dp (
    .clk(clk), .stb(stb), .xIn(xIn), .yOut(yOut), .yValid(yValid)
  );
endmodule

// File: rtl/firChk.sv
module firChk #(
  parameter int DATA_W = 12,
  parameter int TAPS   = 41
) (
  input logic                     clk,
  input logic                     rst,
  input logic signed [DATA_W-1:0] xIn,
  input logic signed [DATA_W-1:0] yOut,
  input logic                     yValid
);
  localparam int FILL  = TAPS + 3;
  localparam int CNT_W = $clog2(FILL + 1);
  localparam logic [CNT_W-1:0] FILL_CNT = CNT_W'(FILL);

  logic [CNT_W-1:0] sinceRst;
  logic [CNT_W-1:0] zeroRun;
  logic             prevRst;

  always_ff @(posedge clk) begin
    prevRst <= rst;
    if (rst) begin
      sinceRst <= '0;
      zeroRun  <= FILL_CNT;
    end else begin
      if (sinceRst != FILL_CNT) sinceRst <= sinceRst + 1'b1;
      if (xIn != '0)                 zeroRun <= '0;
      else if (zeroRun != FILL_CNT)  zeroRun <= zeroRun + 1'b1;
    end
  end

  // R8
  always @(negedge clk) begin
    if (prevRst === 1'b1) begin
      reset_out_chk: assert (yOut == '0 && !yValid);
    end
  end

  // R9
  fill_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sinceRst < FILL_CNT) |-> !yValid);

  // R9
  fill_high_chk: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == FILL_CNT) |-> yValid);

  // R9
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    yValid |=> yValid);

  // R10
  zero_out_chk: assert property (@(posedge clk) disable iff (rst)
    (zeroRun == FILL_CNT) |-> (yOut == '0));
endmodule

bind symFirApprox firChk #(.DATA_W(DATA_W), .TAPS(TAPS)) chk (
  .clk(clk), .rst(rst), .xIn(xIn), .yOut(yOut), .yValid(yValid)
);

// File: tb/symFirApprox_test.sv
module symFirApprox_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [11:0] xIn = '0;
  logic signed [11:0] yEx, yAx, yFull;
  logic vEx, vAx, vFull;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string phaseTag = "R8";

  always #4 clk = ~clk;

  symFirApprox uut (
    .clk(clk), .rst(rst), .xIn(xIn), .yOut(yEx), .yValid(vEx)
  );
  symFirApprox #(.PRE_APPROX(10), .ACC_APPROX(12)) uutAx (
    .clk(clk), .rst(rst), .xIn(xIn), .yOut(yAx), .yValid(vAx)
  );
  symFirApprox #(.PRE_APPROX(13), .ACC_APPROX(24)) uutFull (
    .clk(clk), .rst(rst), .xIn(xIn), .yOut(yFull), .yValid(vFull)
  );

  // Captured-sample history: hist[0] is the newest capture
  logic signed [11:0] hist [48];
  int sinceRst = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 48; i++) hist[i] <= '0;
      sinceRst <= 0;
    end else begin
      hist[0] <= xIn;
      for (int i = 1; i < 48; i++) hist[i] <= hist[i-1];
      if (sinceRst < 1000) sinceRst <= sinceRst + 1;
    end
  end

  function automatic longint sx(input longint v, input int w);
    longint m = (64'sd1 <<< w) - 1;
    longint r = v & m;
    if (((r >>> (w - 1)) & 1) != 0) r = r - (64'sd1 <<< w);
    return r;
  endfunction

  function automatic longint axAdd(input longint a, input longint b,
                                   input int w, input int k);
    longint m  = (64'sd1 <<< w) - 1;
    longint ua = a & m;
    longint ub = b & m;
    longint r, lo, hi, c;
    if (k == 0) r = ua + ub;
    else if (k >= w) r = ua | ub;
    else begin
      lo = (ua | ub) & ((64'sd1 <<< k) - 1);
      c  = (ua >>> (k - 1)) & (ub >>> (k - 1)) & 1;
      hi = ((ua >>> k) + (ub >>> k) + c) <<< k;
      r  = hi | lo;
    end
    return sx(r, w);
  endfunction

  function automatic int coefModel(input int k);
    return (k == 20) ? 64 : 3 * k - 10;
  endfunction

  // Expected output after the current edge (window taken 3 edges back)
  function automatic int expectY(input int pk, input int ak);
    longint prod [21];
    longint acc, p, r;
    for (int k = 0; k < 20; k++) begin
      p = axAdd(longint'(hist[3+k]), longint'(hist[43-k]), 13, pk);
      prod[k] = sx(p * coefModel(k), 24);
    end
    prod[20] = sx(longint'(hist[23]) * coefModel(20), 24);
    acc = prod[0];
    for (int k = 1; k < 21; k++) acc = axAdd(acc, prod[k], 24, ak);
    r = (acc + 128) >>> 8;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return int'(r);
  endfunction

  task automatic checkOne(input string inst, input string rtag,
                          input logic signed [11:0] y, input logic v,
                          input int pk, input int ak);
    int e = expectY(pk, ak);
    bit ev = (sinceRst >= 44);
    checks++;
    if (int'(y) != e) begin
      errors++;
      $display("FAIL %s/%s %s: yOut=%0d expected=%0d", rtag, phaseTag, inst, y, e);
    end
    checks++;
    if (v != ev) begin
      errors++;
      $display("FAIL R9 %s: yValid=%0d expected=%0d", inst, v, ev);
    end
  endtask

  task automatic checkAll();
    if (rst) begin
      // R8: outputs cleared while reset is held
      checks++;
      if (yEx != 0 || yAx != 0 || yFull != 0 || vEx || vAx || vFull) begin
        errors++;
        $display("FAIL R8: y=%0d/%0d/%0d v=%0d%0d%0d expected all 0",
                 yEx, yAx, yFull, vEx, vAx, vFull);
      end
    end else begin
      checkOne("exact", "R1 R3", yEx, vEx, 0, 0);
      checkOne("ax10_12", "R5 R6", yAx, vAx, 10, 12);
      checkOne("full", "R7", yFull, vFull, 13, 24);
    end
  endtask

  task automatic step(input logic signed [11:0] v);
    @(negedge clk);
    checkAll();
    xIn = v;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1;
    xIn = '0;
    phaseTag = "R8";
    repeat (3) begin
      @(negedge clk);
      checkAll();
    end
    rst = 1'b0;
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    applyReset();
    // R9: fill with zeros, valid rises after the 44th edge
    phaseTag = "R9";
    repeat (50) step(12'sd0);
    // R2: impulses expose each coefficient
    phaseTag = "R2";
    step(12'sd2047);
    repeat (50) step(12'sd0);
    step(-12'sd2048);
    repeat (50) step(12'sd0);
    // R4: positive and negative saturation
    phaseTag = "R4";
    repeat (60) step(12'sd2047);
    repeat (60) step(-12'sd2048);
    // R10: zero run returns output to zero
    phaseTag = "R10";
    repeat (50) step(12'sd0);
    // R1 R3: sweep every input code
    phaseTag = "R1 R3";
    for (int v = -2048; v < 2048; v++) step(12'(v));
    // pseudo-random samples
    phaseTag = "R3";
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[11:0]);
    end
    // alternating large values
    phaseTag = "R4";
    for (int i = 0; i < 100; i++) step(i[0] ? -12'sd1500 : 12'sd1500);
    // R8 R9: reset during activity, then refill
    applyReset();
    phaseTag = "R9";
    repeat (60) step(12'sd300);
    phaseTag = "R10";
    repeat (50) step(12'sd0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule